// File: doc/BRIEF.md
# ADC conversion control sequencer

This block is the control and sequencing logic that sits beside a successive-approximation converter. Software reaches it through a small byte-wide register bus. A control byte turns the converter on, picks the conversion clock, selects how results are aligned and starts conversions through a go/busy bit. The analog core reports the end of each conversion with a one-cycle strobe and a 10-bit raw code. The block captures that code, moves the older code into a previous-result register, and either ends the cycle or starts the next conversion at once.

In continuous mode the go bit is restarted after every completed conversion. The repetition ends when software clears the go bit. It also ends when the stop-on-interrupt input is high and the threshold-interrupt flag is high in the cycle the conversion completes. Both result registers are presented as 16-bit values. The chosen alignment is applied when they are read, so a change of format affects the stored current and previous codes alike.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Bus address 0 reads the control byte with enable in bit 7, continuous in bit 6, clock select in bit 4, format in bit 2 and go in bit 0. Bits 5, 3 and 1 always read 0. A bus write to address 0 loads all five fields in the same positions.
- R2: After a synchronous reset every control field is 0, and the current and previous raw results are 0.
- R3: A write to address 0 with bit 0 and bit 7 both 1, while go is 0 or a conversion completes in that cycle, sets go. In the following cycle `conv_start` is high for one cycle. `conv_start` is never high while go reads 0.
- R4: A control write with bit 7 at 0 leaves go at 0, even if bit 0 is 1, and does not raise `conv_start`.
- R5: With continuous mode off, an accepted completion (`conv_done` high while go is 1, with no control write in that cycle) clears go.
- R6: With continuous mode on, an accepted completion keeps go at 1 and raises `conv_start` in the next cycle, unless R7 applies.
- R7: With continuous mode on, an accepted completion clears go when `stop_on_irq` and `thresh_flag` are both high in that cycle.
- R8: A control write with bit 0 at 0 clears go, including in continuous mode, whatever the value of `stop_on_irq`.
- R9: When a control write and an accepted completion fall in the same cycle, go takes the written value. The raw result is still captured.
- R10: `conv_clk` follows `rc_clk` when clock select is 1 and `div_clk` when it is 0.
- R11: With format 1 a result reads right-justified as {6'b0, raw}. With format 0 it reads left-justified as {raw, 6'b0}. Address 1 gives the high byte and address 2 the low byte of the current result. Addresses 3 and 4 give the high and low bytes of the previous result. Addresses 5 to 7 read 0.
- R12: An accepted completion copies the current raw result into the previous result and loads the new code. A `conv_done` while go is 0 changes neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| conv_done | input | 1 | One-cycle completion strobe from the analog core |
| conv_data | input | RAW_W | Raw conversion code, valid with `conv_done` |
| thresh_flag | input | 1 | Threshold interrupt flag |
| stop_on_irq | input | 1 | Stop continuous mode when the flag is set |
| rc_clk | input | 1 | Dedicated internal RC clock |
| div_clk | input | 1 | Divided system clock |
| conv_clk | output | 1 | Selected conversion clock |
| conv_start | output | 1 | One-cycle pulse that starts a conversion |
| adc_on | output | 1 | Enable to the analog core |

## Verification
The riskiest overlap is a software write to the control byte that lands in the same cycle as a completion strobe. In that cycle the hardware clear or restart and the software value compete for the go bit. Directed steps drive both in one cycle, in single and in continuous mode and with go written as 1 and as 0. The random phase produces many more such collisions. Each outcome is judged against a bench model in which the written value wins, while the result capture and the previous-result shift still take place.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    // bit positions inside the control byte
    localparam int unsigned CB_EN   = 7;
    localparam int unsigned CB_CONT = 6;
    localparam int unsigned CB_CSEL = 4;
    localparam int unsigned CB_FMT  = 2;
    localparam int unsigned CB_GO   = 0;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned RES_W   = 2 * BYTE_W;

    typedef struct packed {
        logic en;
        logic cont;
        logic csel;
        logic fmt;
        logic go;
    } ctl_t;

    typedef enum logic [2:0] {
        A_CTRL    = 3'd0,
        A_RES_HI  = 3'd1,
        A_RES_LO  = 3'd2,
        A_PREV_HI = 3'd3,
        A_PREV_LO = 3'd4
    } addr_e;

    function automatic logic [BYTE_W-1:0] pack_ctl(input ctl_t c);
        logic [BYTE_W-1:0] r;
        r          = '0;
        r[CB_EN]   = c.en;
        r[CB_CONT] = c.cont;
        r[CB_CSEL] = c.csel;
        r[CB_FMT]  = c.fmt;
        r[CB_GO]   = c.go;
        return r;
    endfunction
endpackage

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              conv_done,
    input  logic              thresh_flag,
    input  logic              stop_on_irq,
    output ctl_t              ctl,
    output logic              accept,
    output logic              conv_start
);
    ctl_t ctl_q, ctl_d;
    logic start_q, start_d, retrig;

    assign accept = conv_done & ctl_q.go;
    assign retrig = ctl_q.cont & ~(stop_on_irq & thresh_flag);

    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctrl) begin
            ctl_d.en   = wdata[CB_EN];
            ctl_d.cont = wdata[CB_CONT];
            ctl_d.csel = wdata[CB_CSEL];
            ctl_d.fmt  = wdata[CB_FMT];
            ctl_d.go   = wdata[CB_GO] & wdata[CB_EN];
        end else if (accept) begin
            ctl_d.go = retrig;
        end
        start_d = ctl_d.go & (~ctl_q.go | accept);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            start_q <= 1'b0;
        end else begin
            ctl_q   <= ctl_d;
            start_q <= start_d;
        end
    end

    assign ctl        = ctl_q;
    assign conv_start = start_q;
endmodule

// File: rtl/adc_result_store.sv
module adc_result_store
    import adc_seq_pkg::*;
#(
    parameter int unsigned RAW_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [RAW_W-1:0] raw_in,
    input  logic             right,
    output logic [RAW_W-1:0] cur_raw,
    output logic [RES_W-1:0] cur_fmt,
    output logic [RES_W-1:0] prev_fmt
);
    localparam int unsigned PAD = RES_W - RAW_W;

    logic [RAW_W-1:0] cur_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            prev_q <= '0;
        end else if (load) begin
            prev_q <= cur_q;
            cur_q  <= raw_in;
        end
    end

    function automatic logic [RES_W-1:0] justify(input logic [RAW_W-1:0] v, input logic r);
        logic [RES_W-1:0] w;
        w = {{PAD{1'b0}}, v};
        return r ? w : (w << PAD);
    endfunction

    assign cur_raw  = cur_q;
    assign cur_fmt  = justify(cur_q, right);
    assign prev_fmt = justify(prev_q, right);
endmodule

// File: rtl/adc_clk_sel.sv
module adc_clk_sel (
    input  logic sel_rc,
    input  logic rc_clk,
    input  logic div_clk,
    output logic clk_out
);
    assign clk_out = sel_rc ? rc_clk : div_clk;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned RAW_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              conv_done,
    input  logic [RAW_W-1:0]  conv_data,
    input  logic              thresh_flag,
    input  logic              stop_on_irq,
    input  logic              rc_clk,
    input  logic              div_clk,
    output logic              conv_clk,
    output logic              conv_start,
    output logic              adc_on
);
    ctl_t             ctl;
    logic             wr_ctrl;
    logic             accept;
    logic [RAW_W-1:0] res_raw;
    logic [RES_W-1:0] cur_fmt, prev_fmt;

    assign wr_ctrl = bus_wr & (addr_e'(bus_addr) == A_CTRL);

    adc_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_ctrl    (wr_ctrl),
        .wdata      (bus_wdata),
        .conv_done  (conv_done),
        .thresh_flag(thresh_flag),
        .stop_on_irq(stop_on_irq),
        .ctl        (ctl),
        .accept     (accept),
        .conv_start (conv_start)
    );

    adc_result_store #(.RAW_W(RAW_W)) u_res (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .raw_in  (conv_data),
        .right   (ctl.fmt),
        .cur_raw (res_raw),
        .cur_fmt (cur_fmt),
        .prev_fmt(prev_fmt)
    );

    adc_clk_sel u_clk (
        .sel_rc (ctl.csel),
        .rc_clk (rc_clk),
        .div_clk(div_clk),
        .clk_out(conv_clk)
    );

    always_comb begin
        case (addr_e'(bus_addr))
            A_CTRL:    bus_rdata = pack_ctl(ctl);
            A_RES_HI:  bus_rdata = cur_fmt[RES_W-1:BYTE_W];
            A_RES_LO:  bus_rdata = cur_fmt[BYTE_W-1:0];
            A_PREV_HI: bus_rdata = prev_fmt[RES_W-1:BYTE_W];
            A_PREV_LO: bus_rdata = prev_fmt[BYTE_W-1:0];
            default:   bus_rdata = '0;
        endcase
    end

    assign adc_on = ctl.en;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int unsigned RAW_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_ctrl,
    input logic             conv_done,
    input logic             thresh_flag,
    input logic             stop_on_irq,
    input logic             en,
    input logic             cont,
    input logic             go,
    input logic             conv_start,
    input logic [RAW_W-1:0] res_raw,
    input logic [2:0]       bus_addr,
    input logic [7:0]       bus_rdata
);
    assert_unimpl_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd0) |-> (bus_rdata[5] == 1'b0 && bus_rdata[3] == 1'b0 && bus_rdata[1] == 1'b0));

    assert_start_busy_R3: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> go);

    assert_go_needs_en_R4: assert property (@(posedge clk) disable iff (rst)
        go |-> en);

    assert_single_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (conv_done && go && !cont && !wr_ctrl) |=> !go);

    assert_cont_retrig_R6: assert property (@(posedge clk) disable iff (rst)
        (conv_done && go && cont && !(stop_on_irq && thresh_flag) && !wr_ctrl) |=> (go && conv_start));

    assert_irq_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (conv_done && go && cont && stop_on_irq && thresh_flag && !wr_ctrl) |=> !go);

    assert_idle_done_ignored_R12: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !go) |=> $stable(res_raw));
endmodule

bind adc_seq_ctrl adc_seq_chk #(.RAW_W(RAW_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_ctrl    (wr_ctrl),
    .conv_done  (conv_done),
    .thresh_flag(thresh_flag),
    .stop_on_irq(stop_on_irq),
    .en         (ctl.en),
    .cont       (ctl.cont),
    .go         (ctl.go),
    .conv_start (conv_start),
    .res_raw    (res_raw),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
    localparam int RAW_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_wr = 1'b0;
    logic [2:0]       bus_addr = '0;
    logic [7:0]       bus_wdata = '0;
    logic [7:0]       bus_rdata;
    logic             conv_done = 1'b0;
    logic [RAW_W-1:0] conv_data = '0;
    logic             thresh_flag = 1'b0;
    logic             stop_on_irq = 1'b0;
    logic             rc_clk = 1'b1;
    logic             div_clk = 1'b0;
    logic             conv_clk, conv_start, adc_on;

    int errors = 0;
    int checks = 0;
    logic done_run = 1'b0;

    // bench model
    logic m_en, m_cont, m_cs, m_fmt, m_go, m_start;
    logic [RAW_W-1:0] m_cur, m_prev;

    always #2 clk = ~clk;

    adc_seq_ctrl #(.RAW_W(RAW_W)) u_adc_seq_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_done(conv_done),
        .conv_data(conv_data), .thresh_flag(thresh_flag), .stop_on_irq(stop_on_irq),
        .rc_clk(rc_clk), .div_clk(div_clk), .conv_clk(conv_clk),
        .conv_start(conv_start), .adc_on(adc_on)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] just(input logic [RAW_W-1:0] v, input logic r);
        return r ? {6'b0, v} : {v, 6'b0};
    endfunction

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        logic [15:0] c, p;
        c = just(m_cur, m_fmt);
        p = just(m_prev, m_fmt);
        case (a)
            3'd0: return {m_en, m_cont, 1'b0, m_cs, 1'b0, m_fmt, 1'b0, m_go};
            3'd1: return c[15:8];
            3'd2: return c[7:0];
            3'd3: return p[15:8];
            3'd4: return p[7:0];
            default: return 8'h00;
        endcase
    endfunction

    // one cycle: drive at negedge, advance model at posedge, check at next negedge
    task automatic step(input logic wr, input logic [2:0] a, input logic [7:0] wd,
                        input logic dn, input logic [RAW_W-1:0] dat,
                        input logic fl, input logic soi, input string tag);
        logic acc, ngo, nst;
        bus_wr = wr; bus_addr = a; bus_wdata = wd;
        conv_done = dn; conv_data = dat; thresh_flag = fl; stop_on_irq = soi;
        acc = dn & m_go;
        ngo = m_go;
        if (wr && a == 3'd0) ngo = wd[0] & wd[7];
        else if (acc) ngo = m_cont & ~(soi & fl);
        nst = ngo & (~m_go | acc);
        @(posedge clk);
        if (wr && a == 3'd0) begin
            m_en = wd[7]; m_cont = wd[6]; m_cs = wd[4]; m_fmt = wd[2];
        end
        if (acc) begin
            m_prev = m_cur;
            m_cur  = dat;
        end
        m_go = ngo;
        m_start = nst;
        @(negedge clk);
        chk({tag, " rdata"}, {8'h00, bus_rdata}, {8'h00, exp_read(a)});
        chk("R3 conv_start", {15'h0, conv_start}, {15'h0, m_start});
        chk("R10 conv_clk", {15'h0, conv_clk}, {15'h0, (m_cs ? rc_clk : div_clk)});
        bus_wr = 1'b0; conv_done = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        step(1'b0, a, 8'h00, 1'b0, '0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #400000;
        if (!done_run) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_en = 0; m_cont = 0; m_cs = 0; m_fmt = 0; m_go = 0; m_start = 0;
        m_cur = '0; m_prev = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R2 reset state
        chk("R2 ctrl after reset", {8'h00, bus_rdata}, 16'h0000);
        rd(3'd1, "R2"); rd(3'd2, "R2"); rd(3'd3, "R2"); rd(3'd4, "R2");
        // R4 go without enable
        step(1'b1, 3'd0, 8'h01, 1'b0, '0, 1'b0, 1'b0, "R4");
        // R1 all fields, unimplemented bits read 0
        step(1'b1, 3'd0, 8'hFF, 1'b0, '0, 1'b0, 1'b0, "R1");
        chk("R1 full byte", {8'h00, bus_rdata}, 16'h00D5);
        step(1'b1, 3'd0, 8'h00, 1'b0, '0, 1'b0, 1'b0, "R8");
        // R3 start, R5 single clear
        step(1'b1, 3'd0, 8'h81, 1'b0, '0, 1'b0, 1'b0, "R3");
        step(1'b0, 3'd0, 8'h00, 1'b1, 10'h3A5, 1'b0, 1'b0, "R5");
        rd(3'd1, "R11"); chk("R11 left hi", {8'h00, bus_rdata}, 16'h00E9);
        rd(3'd2, "R11"); chk("R11 left lo", {8'h00, bus_rdata}, 16'h0040);
        // done while idle ignored
        step(1'b0, 3'd1, 8'h00, 1'b1, 10'h0FF, 1'b0, 1'b0, "R12");
        // right-justified, previous shift
        step(1'b1, 3'd0, 8'h85, 1'b0, '0, 1'b0, 1'b0, "R3");
        step(1'b0, 3'd3, 8'h00, 1'b1, 10'h155, 1'b0, 1'b0, "R12");
        chk("R12 prev hi", {8'h00, bus_rdata}, 16'h0003);
        rd(3'd4, "R12"); chk("R12 prev lo", {8'h00, bus_rdata}, 16'h00A5);
        rd(3'd2, "R11"); chk("R11 right lo", {8'h00, bus_rdata}, 16'h0055);
        rd(3'd6, "R11");
        // R6 continuous retrigger
        step(1'b1, 3'd0, 8'hC1, 1'b0, '0, 1'b0, 1'b1, "R6");
        step(1'b0, 3'd0, 8'h00, 1'b1, 10'h001, 1'b0, 1'b1, "R6");
        chk("R6 restart pulse", {15'h0, conv_start}, 16'h0001);
        step(1'b0, 3'd0, 8'h00, 1'b1, 10'h002, 1'b1, 1'b0, "R6");
        // R7 stop on threshold flag
        step(1'b0, 3'd0, 8'h00, 1'b1, 10'h003, 1'b1, 1'b1, "R7");
        chk("R7 go cleared", {15'h0, bus_rdata[0]}, 16'h0000);
        // R8 software clear in continuous mode, both stop settings
        step(1'b1, 3'd0, 8'hC1, 1'b0, '0, 1'b0, 1'b0, "R8");
        step(1'b1, 3'd0, 8'hC0, 1'b0, '0, 1'b0, 1'b1, "R8");
        step(1'b1, 3'd0, 8'hC1, 1'b0, '0, 1'b0, 1'b1, "R8");
        step(1'b1, 3'd0, 8'hC0, 1'b0, '0, 1'b0, 1'b0, "R8");
        // R9 write vs completion in one cycle
        step(1'b1, 3'd0, 8'h81, 1'b0, '0, 1'b0, 1'b0, "R9");
        step(1'b1, 3'd0, 8'h81, 1'b1, 10'h2AA, 1'b0, 1'b0, "R9");
        chk("R9 write kept go", {15'h0, bus_rdata[0]}, 16'h0001);
        step(1'b1, 3'd0, 8'hC0, 1'b1, 10'h133, 1'b0, 1'b0, "R9");
        chk("R9 write cleared go", {15'h0, bus_rdata[0]}, 16'h0000);
        rd(3'd1, "R9");
        // R10 clock select both ways
        step(1'b1, 3'd0, 8'h90, 1'b0, '0, 1'b0, 1'b0, "R10");
        rc_clk = 1'b0; div_clk = 1'b1;
        rd(3'd0, "R10");
        // random phase
        void'($urandom(32'h5EED_0A1C));
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] a;
            logic [7:0] wd;
            logic       w;
            string      tg;
            a  = 3'($urandom_range(0, 7));
            w  = ($urandom_range(0, 5) == 0);
            wd = 8'($urandom);
            if ($urandom_range(0, 1) == 1) wd[7] = 1'b1;
            rc_clk  = 1'($urandom);
            div_clk = 1'($urandom);
            tg = (a == 3'd0) ? "R1" : ((a == 3'd3 || a == 3'd4) ? "R12" : "R11");
            step(w, w ? 3'd0 : a, wd, ($urandom_range(0, 2) == 0), RAW_W'($urandom),
                 1'($urandom), 1'($urandom), w ? "R9" : tg);
        end
        done_run = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule